// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper With Mixed Decay

This block regulates the winding current of one H-bridge phase. Every chopping cycle opens with an on-phase that drives the bridge across one diagonal. During an initial blanking window the block ignores the external current-sense comparator. Once the blanking window has run out, a comparator trip ends the on-phase. A fixed off period follows, and its length comes from a three-level select. The off period starts with a fast-decay portion, in which the opposite diagonal conducts. A slow-decay portion follows, in which both low-side switches conduct. A two-bit select sets the fast-decay share.

The block outputs the four gate commands with dead time inserted. All timings are counted in cycles of the system clock. Each one is derived by rounding a time in nanoseconds up to whole cycles at the parameter `CLK_MHZ`. The comparator, the reference DAC and the step sequencer that supplies the phase sign are outside the block. The force-off input and the zero-setpoint input shut the bridge at once and return the chopper to idle.

Top module: `chop_mixdecay`

Gate bit map: bit 0 is the left high side, bit 1 the left low side, bit 2 the right high side and bit 3 the right low side. Positive drive is 4'b1001, negative drive is 4'b0110 and slow decay is 4'b1010.

## Requirements
- R1: While rst_ni is low, gate_o is 4'b0000. After release, the first on-phase drive pattern appears on the gate outputs at the DEAD_C+2-th clock cycle counted from the release cycle.
- R2: off_sel_i 2'b00 selects an off period of 28.0 us, 2'b01 selects 15.2 us, and 2'b10 or 2'b11 selects 8.1 us. Each is converted to cycles rounded up. The non-drive gap between two on-phases equals the off period plus DEAD_C cycles.
- R3: decay_sel_i sets the fast-decay share of the off period to 0 (2'b00), one quarter (2'b01), one half (2'b10) or all of it (2'b11). The share is rounded down to whole cycles, the fast portion comes first, and slow decay fills the remainder.
- R4: A trip is accepted only after DEAD_C+BLANK_C cycles of the on-phase have passed. With trip_i held high, each drive pulse therefore lasts exactly BLANK_C cycles.
- R5: trip_i passes through a two-stage synchronizer. A rising trip during an unblanked on-phase removes the drive pattern four clock cycles after the trip rises.
- R6: Each switch turns off in the cycle after its command is withdrawn. A switch turns on only after DEAD_C cycles in which no switch has changed. The two switches of one leg are never on together.
- R7: force_off_i or setpt_zero_i forces gate_o to 4'b0000 in the same cycle and returns the chopper to idle. After release, drive resumes at the DEAD_C+2-th cycle counted from the release cycle.
- R8: sign_i = 0 drives 4'b1001 and sign_i = 1 drives 4'b0110. The sign is captured only when an on-phase begins, so a change during a chopping cycle takes effect at the next on-phase.
- R9: Fast decay drives the diagonal opposite to the captured on-phase diagonal. Slow decay drives 4'b1010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Current comparator trip, asynchronous |
| off_sel_i | input | 2 | Off-period select (three levels) |
| decay_sel_i | input | 2 | Fast-decay share select |
| sign_i | input | 1 | Phase current sign from the sequencer |
| force_off_i | input | 1 | Immediate bridge shutdown |
| setpt_zero_i | input | 1 | Zero-current setpoint, shuts the bridge |
| gate_o | output | 4 | Gate commands {right low, right high, left low, left high} |

## Verification
The bench builds the block with CLK_MHZ = 10. At that setting the off periods shrink to 280, 152 and 81 cycles, the blanking window to 7 cycles and the dead time to 8 cycles. Every decay share and off-time level then completes within a few hundred cycles, so one run covers each off-time level, each fast-decay share, the rounding of odd shares (81 cycles splitting into 20 and 61, or 40 and 41), and repeated blank-limited pulses with the trip held high. The short dead time also makes the exact gate sequence around each transition observable cycle by cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ON,
    ST_FAST,
    ST_SLOW
  } chop_st_e;

  // gate bits: {right low, right high, left low, left high}
  localparam logic [3:0] GATE_OFF  = 4'b0000;
  localparam logic [3:0] GATE_POS  = 4'b1001;
  localparam logic [3:0] GATE_NEG  = 4'b0110;
  localparam logic [3:0] GATE_LOWS = 4'b1010;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  // a loaded value N keeps done_o low for N-1 cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i - CW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int unsigned CW          = 12,
  parameter int unsigned OFF_LONG_C  = 2800,
  parameter int unsigned OFF_MID_C   = 1520,
  parameter int unsigned OFF_SHORT_C = 810,
  parameter int unsigned ON_MIN_C    = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kill_i,
  input  logic       trip_i,
  input  logic [1:0] off_sel_i,
  input  logic [1:0] decay_sel_i,
  input  logic       sign_i,
  output logic [3:0] target_o
);
  chop_st_e      st_q, st_d;
  logic          sign_q;
  logic [CW-1:0] slow_len_q;
  logic [CW-1:0] off_c, fast_c, ld_val;
  logic          ld, t_done;

  chop_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (t_done)
  );

  always_comb begin
    case (off_sel_i)
      2'b00:   off_c = CW'(OFF_LONG_C);
      2'b01:   off_c = CW'(OFF_MID_C);
      default: off_c = CW'(OFF_SHORT_C);
    endcase
  end

  always_comb begin
    case (decay_sel_i)
      2'b00:   fast_c = '0;
      2'b01:   fast_c = off_c >> 2;
      2'b10:   fast_c = off_c >> 1;
      default: fast_c = off_c;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = CW'(ON_MIN_C);
    if (kill_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d = ST_ON;
          ld   = 1'b1;
        end
        ST_ON: begin
          if (t_done && trip_i) begin
            ld = 1'b1;
            if (fast_c != '0) begin
              st_d   = ST_FAST;
              ld_val = fast_c;
            end else begin
              st_d   = ST_SLOW;
              ld_val = off_c;
            end
          end
        end
        ST_FAST: begin
          if (t_done) begin
            ld = 1'b1;
            if (slow_len_q != '0) begin
              st_d   = ST_SLOW;
              ld_val = slow_len_q;
            end else begin
              st_d = ST_ON;
            end
          end
        end
        ST_SLOW: begin
          if (t_done) begin
            ld   = 1'b1;
            st_d = ST_ON;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sign_q     <= 1'b0;
      slow_len_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ON && (st_d == ST_FAST || st_d == ST_SLOW))
        slow_len_q <= off_c - fast_c;
      if (st_d == ST_ON && st_q != ST_ON)
        sign_q <= sign_i;
    end
  end

  always_comb begin
    case (st_q)
      ST_ON:   target_o = sign_q ? GATE_NEG : GATE_POS;
      ST_FAST: target_o = sign_q ? GATE_POS : GATE_NEG;
      ST_SLOW: target_o = GATE_LOWS;
      default: target_o = GATE_OFF;
    endcase
  end

  assert_kill_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> st_q == ST_IDLE);

  assert_blank_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && !kill_i && trip_i && !t_done) |=> st_q == ST_ON);

  assert_fast_needs_share_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_FAST) |-> $past(decay_sel_i) != 2'b00);

  assert_sign_at_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sign_q) |-> (st_q == ST_ON && $past(st_q) != ST_ON));
endmodule

// File: rtl/chop_deadband.sv
module chop_deadband #(
  parameter int unsigned DEAD_C = 80,
  localparam int unsigned GW    = $clog2(DEAD_C + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kill_i,
  input  logic [3:0] target_i,
  output logic [3:0] gate_o
);
  logic [3:0]    cur_q, tgt_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      tgt_q <= '0;
      gap_q <= '0;
    end else if (kill_i) begin
      cur_q <= '0;
      tgt_q <= '0;
      gap_q <= '0;
    end else begin
      tgt_q <= target_i;
      if (target_i != tgt_q) begin
        // withdraw dropped switches now, start the dead-time wait
        cur_q <= cur_q & target_i;
        gap_q <= GW'(DEAD_C);
      end else begin
        if (gap_q == GW'(1)) cur_q <= target_i;
        if (gap_q != '0)     gap_q <= gap_q - GW'(1);
      end
    end
  end

  assign gate_o = cur_q;

  assert_leg_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cur_q[0] && cur_q[1]) && !(cur_q[2] && cur_q[3]));

  assert_on_not_with_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cur_q & ~$past(cur_q))) |-> (($past(cur_q) & ~cur_q) == 4'b0000));
endmodule

// File: rtl/chop_mixdecay.sv
module chop_mixdecay
  import chop_pkg::*;
#(
  parameter int unsigned CLK_MHZ        = 100,
  parameter int unsigned T_OFF_LONG_NS  = 28000,
  parameter int unsigned T_OFF_MID_NS   = 15200,
  parameter int unsigned T_OFF_SHORT_NS = 8100,
  parameter int unsigned T_BLANK_NS     = 700,
  parameter int unsigned T_DEAD_NS      = 800,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trip_i,
  input  logic [1:0] off_sel_i,
  input  logic [1:0] decay_sel_i,
  input  logic       sign_i,
  input  logic       force_off_i,
  input  logic       setpt_zero_i,
  output logic [3:0] gate_o
);
  localparam int unsigned OFF_LONG_C  = ns_to_cyc(T_OFF_LONG_NS, CLK_MHZ);
  localparam int unsigned OFF_MID_C   = ns_to_cyc(T_OFF_MID_NS, CLK_MHZ);
  localparam int unsigned OFF_SHORT_C = ns_to_cyc(T_OFF_SHORT_NS, CLK_MHZ);
  localparam int unsigned BLANK_RAW   = ns_to_cyc(T_BLANK_NS, CLK_MHZ);
  localparam int unsigned DEAD_RAW    = ns_to_cyc(T_DEAD_NS, CLK_MHZ);
  localparam int unsigned BLANK_C     = (BLANK_RAW == 0) ? 1 : BLANK_RAW;
  localparam int unsigned DEAD_C      = (DEAD_RAW == 0) ? 1 : DEAD_RAW;
  localparam int unsigned ON_MIN_C    = DEAD_C + BLANK_C;
  localparam int unsigned CW          = $clog2(OFF_LONG_C + OFF_MID_C + OFF_SHORT_C + ON_MIN_C + 1);

  logic       kill, trip_s;
  logic [3:0] target, gate_raw;

  assign kill = force_off_i | setpt_zero_i;

  chop_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (trip_i),
    .q_o    (trip_s)
  );

  chop_fsm #(
    .CW          (CW),
    .OFF_LONG_C  (OFF_LONG_C),
    .OFF_MID_C   (OFF_MID_C),
    .OFF_SHORT_C (OFF_SHORT_C),
    .ON_MIN_C    (ON_MIN_C)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kill_i      (kill),
    .trip_i      (trip_s),
    .off_sel_i   (off_sel_i),
    .decay_sel_i (decay_sel_i),
    .sign_i      (sign_i),
    .target_o    (target)
  );

  chop_deadband #(.DEAD_C(DEAD_C)) i_deadband (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kill_i   (kill),
    .target_i (target),
    .gate_o   (gate_raw)
  );

  // shutdown path bypasses every register
  assign gate_o = kill ? GATE_OFF : gate_raw;

  assert_release_dark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(kill) |-> gate_o == GATE_OFF);
endmodule

// File: tb/test_chop_mixdecay.sv
module test_chop_mixdecay;
  localparam int DEAD  = 8;
  localparam int BLANK = 7;
  localparam int OFF_SHORT = 81;
  localparam logic [3:0] G_POS  = 4'b1001;
  localparam logic [3:0] G_NEG  = 4'b0110;
  localparam logic [3:0] G_LOWS = 4'b1010;

  typedef struct packed {
    logic [1:0] off;
    logic [1:0] dec;
    logic       sg;
    int         fast;
    int         slow;
  } vec_t;

  // expected counts: full fast/slow pattern cycles = share - DEAD (0 if share is 0)
  localparam vec_t VECS [10] = '{
    '{2'b00, 2'b00, 1'b0,   0, 272},
    '{2'b00, 2'b01, 1'b0,  62, 202},
    '{2'b00, 2'b10, 1'b1, 132, 132},
    '{2'b00, 2'b11, 1'b1, 272,   0},
    '{2'b01, 2'b01, 1'b0,  30, 106},
    '{2'b01, 2'b10, 1'b0,  68,  68},
    '{2'b10, 2'b01, 1'b1,  12,  53},
    '{2'b10, 2'b10, 1'b1,  32,  33},
    '{2'b11, 2'b11, 1'b1,  73,   0},
    '{2'b11, 2'b00, 1'b0,   0,  73}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip = 1'b0;
  logic [1:0] off_sel = 2'b10;
  logic [1:0] decay_sel = 2'b11;
  logic       sign = 1'b0;
  logic       force_off = 1'b0;
  logic       setpt_zero = 1'b0;
  logic [3:0] gate;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic cur_sign = 1'b0;

  always #2 clk = ~clk;

  chop_mixdecay #(.CLK_MHZ(10)) i_chop_mixdecay (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .trip_i       (trip),
    .off_sel_i    (off_sel),
    .decay_sel_i  (decay_sel),
    .sign_i       (sign),
    .force_off_i  (force_off),
    .setpt_zero_i (setpt_zero),
    .gate_o       (gate)
  );

  function automatic logic [3:0] drv(input logic s);
    return s ? G_NEG : G_POS;
  endfunction

  function automatic logic [3:0] fst(input logic s);
    return s ? G_POS : G_NEG;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pat(input logic [3:0] p, output int k);
    k = 1;
    @(negedge clk);
    while (gate != p && k < 4000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int fast_n, slow_n, k;
    bit fin;
    off_sel   = v.off;
    decay_sel = v.dec;
    sign      = v.sg;
    repeat (3) @(negedge clk);
    trip = 1'b1;
    k = 0;
    while (gate == drv(cur_sign) && k < 4000) begin
      @(negedge clk);
      k++;
    end
    trip = 1'b0;
    fast_n = 0;
    slow_n = 0;
    fin = 1'b0;
    k = 0;
    while (!fin && k < 4000) begin
      if (gate == drv(v.sg) && ((v.slow == 0) ? (fast_n > 0) : (slow_n > 0))) fin = 1'b1;
      else begin
        if (gate == fst(cur_sign)) fast_n++;
        if (gate == G_LOWS) slow_n++;
        @(negedge clk);
        k++;
      end
    end
    check({tag, " R3 R9 fast-decay cycles"}, fast_n, v.fast);
    check({tag, " R2 R3 R9 slow-decay cycles"}, slow_n, v.slow);
    check({tag, " R8 next drive uses new sign"}, int'(gate), int'(drv(v.sg)));
    cur_sign = v.sg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k, z, w;
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 gates off in reset", int'(gate), 0);
    rst_n = 1'b1;
    wait_pat(G_POS, k);
    check("R1 first drive delay", k, DEAD + 2);

    // R5 synchronizer latency, R6 dead gap (all-fast decay)
    repeat (20) @(negedge clk);
    trip = 1'b1;
    k = 0;
    while (gate == G_POS && k < 100) begin
      @(negedge clk);
      k++;
    end
    trip = 1'b0;
    check("R5 trip to drive removal", k, 4);
    z = 0;
    while (gate == 4'b0000 && z < 100) begin
      z++;
      @(negedge clk);
    end
    check("R6 dead gap all switches off", z, DEAD);
    check("R9 fast pattern after gap", int'(gate), int'(G_NEG));
    wait_pat(G_POS, k);

    // R2/R3/R8/R9 vector table
    foreach (VECS[i]) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R4 blanking floor and R2 period with trip held high
    off_sel   = 2'b10;
    decay_sel = 2'b00;
    trip      = 1'b1;
    k = 0;
    while (gate == drv(cur_sign) && k < 4000) begin
      @(negedge clk);
      k++;
    end
    wait_pat(drv(cur_sign), k);
    w = 0;
    while (gate == drv(cur_sign) && w < 4000) begin
      w++;
      @(negedge clk);
    end
    check("R4 blank-limited drive width", w, BLANK);
    z = 0;
    while (gate != drv(cur_sign) && z < 4000) begin
      z++;
      @(negedge clk);
    end
    check("R2 short off gap with dead time", z, OFF_SHORT + DEAD);
    trip = 1'b0;
    wait_pat(drv(cur_sign), k);

    // R8 sign change inside on-phase waits for the next on-phase
    repeat (5) @(negedge clk);
    sign = ~cur_sign;
    repeat (20) @(negedge clk);
    check("R8 mid on-phase sign ignored", int'(gate), int'(drv(cur_sign)));
    run_vec('{2'b10, 2'b01, ~cur_sign, 12, 53}, "sign");

    // R7 force off and zero setpoint
    repeat (10) @(negedge clk);
    force_off = 1'b1;
    #1;
    check("R7 force off immediate", int'(gate), 0);
    repeat (5) @(negedge clk);
    check("R7 force off held", int'(gate), 0);
    force_off = 1'b0;
    wait_pat(drv(cur_sign), k);
    check("R7 restart after force", k, DEAD + 2);
    repeat (10) @(negedge clk);
    setpt_zero = 1'b1;
    #1;
    check("R7 zero setpoint immediate", int'(gate), 0);
    @(negedge clk);
    setpt_zero = 1'b0;
    #1;
    check("R7 dark right after release", int'(gate), 0);
    wait_pat(drv(cur_sign), k);
    check("R7 restart after zero setpoint", k, DEAD + 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule